// File: doc/BRIEF.md
# Dual-Lane Byte Serializer and Path Router for a Synchronous User-Data Port

This block sits at the user-data edge of a line transceiver. On the transmit side it takes bytes qualified by a valid/request handshake and breaks each byte into bit pairs. Each pair is driven on two lanes: lane 0 carries the even-numbered bit and lane 1 the odd-numbered bit. The pairs go to one of two destinations, a low-latency (fast) path or an interleaved path. A configuration register picks the path. When address routing is enabled, a per-transfer address input picks it instead. A frame pulse marks the start of a superframe. The first byte accepted after that pulse carries a start flag on the path it goes to.

The receive side works the other way round. It takes lane pairs from the path named by the configuration register and rebuilds them into bytes. A start flag on an incoming pair resets the pair count, and the byte that follows is marked as the first byte of a superframe.

Top module: `stm_lane_router`

## Requirements
- R1: After reset, tx_req is 1, fast_vld, ilv_vld, fast_start and ilv_start are 0, and rx_val and rx_frame are 0. The path register resets to 0 (fast) and the mode register resets to 0 (register routing).
- R2: A byte is taken in on a rising edge where tx_val and tx_req are both 1. It then appears as four consecutive valid cycles starting in the next cycle. Cycle k (k = 0..3) carries bit 2k on lane 0 and bit 2k+1 on lane 1, so the least significant pair comes first.
- R3: tx_req is 0 from the edge that takes a byte until its fourth pair has been shown. While tx_req is 0, tx_val and tx_byte are ignored, so the byte in flight is never changed.
- R4: With mode 0 (cfg_mode=0), path register 0 sends a byte to the fast outputs and path register 1 sends it to the interleaved outputs. The other path's valid stays 0. A cfg_we write takes effect from the following edge.
- R5: With mode 1, tx_addr is sampled on the edge that takes the byte: 0 selects fast and 1 selects interleaved. The path register is not used.
- R6: The path is fixed when a byte is taken. Register or address changes during the byte do not move its remaining pairs.
- R7: The first byte taken on or after a tx_sof pulse raises the start output of its path during its first pair cycle only. Later bytes carry no start until the next pulse.
- R8: The receive side takes pairs only from the path named by the path register (0 fast, 1 interleaved). Valid pairs on the other path are ignored. After four valid pairs, rx_byte holds lane-0 bits at even positions and lane-1 bits at odd positions, with the first pair at bits 1:0. rx_val is 1 for the one cycle after the edge that takes the fourth pair.
- R9: A receive pair with its start input at 1 is taken as pair 0 of a new byte, even if pairs were pending. rx_frame is 1 together with rx_val for that byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the path and mode registers |
| cfg_path | input | 1 | Path register value: 0 fast, 1 interleaved |
| cfg_mode | input | 1 | Mode register value: 0 register routing, 1 address routing |
| tx_byte | input | BYTE_W | Transmit byte |
| tx_val | input | 1 | Transmit byte valid |
| tx_addr | input | 1 | Per-transfer path select, used in mode 1 |
| tx_sof | input | 1 | Superframe start pulse |
| tx_req | output | 1 | Ready to take a byte |
| fast_l0 | output | 1 | Fast path even-bit lane |
| fast_l1 | output | 1 | Fast path odd-bit lane |
| fast_vld | output | 1 | Fast path pair valid |
| fast_start | output | 1 | Fast path superframe start flag |
| ilv_l0 | output | 1 | Interleaved path even-bit lane |
| ilv_l1 | output | 1 | Interleaved path odd-bit lane |
| ilv_vld | output | 1 | Interleaved path pair valid |
| ilv_start | output | 1 | Interleaved path superframe start flag |
| rx_fast_l0 | input | 1 | Received fast even-bit lane |
| rx_fast_l1 | input | 1 | Received fast odd-bit lane |
| rx_fast_vld | input | 1 | Received fast pair valid |
| rx_fast_start | input | 1 | Received fast superframe start |
| rx_ilv_l0 | input | 1 | Received interleaved even-bit lane |
| rx_ilv_l1 | input | 1 | Received interleaved odd-bit lane |
| rx_ilv_vld | input | 1 | Received interleaved pair valid |
| rx_ilv_start | input | 1 | Received interleaved superframe start |
| rx_byte | output | BYTE_W | Rebuilt byte |
| rx_val | output | 1 | Rebuilt byte valid, one cycle |
| rx_frame | output | 1 | Rebuilt byte is superframe byte 0 |

## Verification
The bench keeps tx_val high with a different byte while a byte is being sent. A design that reloads its holding register early would show the new byte's bits partway through the old one. It changes the path register in the middle of a byte and checks that the remaining pairs stay on the first path, which a design that routes from the live register would fail. It uses asymmetric byte values so that swapped lanes or a reversed pair order show up as wrong bits. It places the frame pulse both before and on the accept edge, which catches a start flag that is lost or repeated. On receive, it sends traffic on the unselected path and a start flag after stray pairs. A misaligned or unfiltered combiner would then produce a wrong byte or a missing frame mark.

// File: rtl/stm_lane_router.sv
module stm_lane_router #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_path,
  input  logic              cfg_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_val,
  input  logic              tx_addr,
  input  logic              tx_sof,
  output logic              tx_req,
  output logic              fast_l0,
  output logic              fast_l1,
  output logic              fast_vld,
  output logic              fast_start,
  output logic              ilv_l0,
  output logic              ilv_l1,
  output logic              ilv_vld,
  output logic              ilv_start,
  input  logic              rx_fast_l0,
  input  logic              rx_fast_l1,
  input  logic              rx_fast_vld,
  input  logic              rx_fast_start,
  input  logic              rx_ilv_l0,
  input  logic              rx_ilv_l1,
  input  logic              rx_ilv_vld,
  input  logic              rx_ilv_start,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_val,
  output logic              rx_frame
);
  localparam int PAIRS = BYTE_W / 2;
  localparam int CW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int AW    = BYTE_W - 2;
  localparam logic [CW-1:0] LAST = CW'(PAIRS - 1);

  logic route_path, route_mode;

  logic [BYTE_W-1:0] tx_sh;
  logic [CW-1:0]     tx_cnt;
  logic              tx_busy, tx_path, tx_first, sof_pend;
  logic              tx_take;

  assign tx_req  = !tx_busy;
  assign tx_take = tx_val && tx_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_path <= 1'b0;
      route_mode <= 1'b0;
    end else if (cfg_we) begin
      route_path <= cfg_path;
      route_mode <= cfg_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      tx_cnt   <= '0;
      tx_busy  <= 1'b0;
      tx_path  <= 1'b0;
      tx_first <= 1'b0;
      sof_pend <= 1'b0;
    end else begin
      if (tx_take) begin
        tx_sh    <= tx_byte;
        tx_cnt   <= '0;
        tx_busy  <= 1'b1;
        tx_path  <= route_mode ? tx_addr : route_path;
        tx_first <= sof_pend || tx_sof;
        sof_pend <= 1'b0;
      end else begin
        if (tx_sof) sof_pend <= 1'b1;
        if (tx_busy) begin
          tx_sh    <= tx_sh >> 2;
          tx_cnt   <= tx_cnt + 1'b1;
          tx_first <= 1'b0;
          if (tx_cnt == LAST) tx_busy <= 1'b0;
        end
      end
    end
  end

  assign fast_vld   = tx_busy && !tx_path;
  assign ilv_vld    = tx_busy &&  tx_path;
  assign fast_l0    = fast_vld && tx_sh[0];
  assign fast_l1    = fast_vld && tx_sh[1];
  assign ilv_l0     = ilv_vld  && tx_sh[0];
  assign ilv_l1     = ilv_vld  && tx_sh[1];
  assign fast_start = fast_vld && tx_first;
  assign ilv_start  = ilv_vld  && tx_first;

  logic          sel_vld, sel_l0, sel_l1, sel_start;
  logic [CW-1:0] rx_cnt, eff_cnt;
  logic [AW-1:0] rx_acc;
  logic          rx_sf;

  assign sel_vld   = route_path ? rx_ilv_vld   : rx_fast_vld;
  assign sel_l0    = route_path ? rx_ilv_l0    : rx_fast_l0;
  assign sel_l1    = route_path ? rx_ilv_l1    : rx_fast_l1;
  assign sel_start = route_path ? rx_ilv_start : rx_fast_start;
  assign eff_cnt   = sel_start ? '0 : rx_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt   <= '0;
      rx_acc   <= '0;
      rx_sf    <= 1'b0;
      rx_byte  <= '0;
      rx_val   <= 1'b0;
      rx_frame <= 1'b0;
    end else begin
      rx_val   <= 1'b0;
      rx_frame <= 1'b0;
      if (sel_vld) begin
        rx_acc <= {sel_l1, sel_l0, rx_acc[AW-1:2]};
        if (eff_cnt == LAST) begin
          rx_cnt   <= '0;
          rx_byte  <= {sel_l1, sel_l0, rx_acc};
          rx_val   <= 1'b1;
          rx_frame <= sel_start || rx_sf;
          rx_sf    <= 1'b0;
        end else begin
          rx_cnt <= eff_cnt + 1'b1;
          rx_sf  <= sel_start || rx_sf;
        end
      end
    end
  end
endmodule

// File: rtl/stm_lane_router_chk.sv
module stm_lane_router_chk #(
  parameter int PAIRS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tx_val,
  input logic tx_req,
  input logic fast_vld,
  input logic ilv_vld,
  input logic fast_start,
  input logic ilv_start,
  input logic rx_val
);
  logic [7:0] run;
  logic       any_vld;
  assign any_vld = fast_vld || ilv_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= any_vld ? run + 1'b1 : '0;
  end

  assert_run_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_vld |-> run < 8'(PAIRS));
  assert_take_emits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_val && tx_req) |=> any_vld);
  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_vld |-> !tx_req);
  assert_one_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_vld && ilv_vld));
  assert_path_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fast_vld) |-> !ilv_vld);
  assert_path_hold_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ilv_vld) |-> !fast_vld);
  assert_start_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_start || ilv_start) |-> (any_vld && run == 8'd0));
  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_val |=> !rx_val);
endmodule

bind stm_lane_router stm_lane_router_chk u_chk (.*);

// File: tb/sim_stm_lane_router.sv
`timescale 1ns/1ps
module sim_stm_lane_router;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_path = 0, cfg_mode = 0;
  logic [7:0] tx_byte = 0;
  logic tx_val = 0, tx_addr = 0, tx_sof = 0, tx_req;
  logic fast_l0, fast_l1, fast_vld, fast_start, ilv_l0, ilv_l1, ilv_vld, ilv_start;
  logic rx_fast_l0 = 0, rx_fast_l1 = 0, rx_fast_vld = 0, rx_fast_start = 0;
  logic rx_ilv_l0 = 0, rx_ilv_l1 = 0, rx_ilv_vld = 0, rx_ilv_start = 0;
  logic [7:0] rx_byte;
  logic rx_val, rx_frame;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  stm_lane_router u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic p, input logic m);
    @(negedge clk);
    cfg_we = 1; cfg_path = p; cfg_mode = m;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // called at the negedge showing pair 0; returns at negedge after pair 3
  task automatic check_pairs(input logic [7:0] b, input logic path, input logic st, input string tag);
    for (int i = 0; i < 4; i++) begin
      logic [1:0] exp_pair, act_pair;
      exp_pair = {b[2*i+1], b[2*i]};
      act_pair = path ? {ilv_l1, ilv_l0} : {fast_l1, fast_l0};
      check(act_pair == exp_pair, {tag, " R2 pair bits"}, act_pair, exp_pair);
      check((path ? ilv_vld : fast_vld) && !(path ? fast_vld : ilv_vld),
            {tag, " R4 path valid"}, {fast_vld, ilv_vld}, path ? 1 : 2);
      check((path ? ilv_start : fast_start) == (st && i == 0) && !(path ? fast_start : ilv_start),
            {tag, " R7 start flag"}, {fast_start, ilv_start}, (st && i == 0) ? (path ? 1 : 2) : 0);
      check(!tx_req, {tag, " R3 req low"}, tx_req, 0);
      @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic addr, input logic sof,
                           input logic path, input logic st, input string tag);
    @(negedge clk);
    while (!tx_req) @(negedge clk);
    tx_val = 1; tx_byte = b; tx_addr = addr; tx_sof = sof;
    @(negedge clk);
    tx_val = 0; tx_sof = 0; tx_byte = 8'hxx === 8'h00 ? 8'h00 : 8'h00;
    check_pairs(b, path, st, tag);
    check(tx_req && !fast_vld && !ilv_vld, {tag, " R3 idle after byte"}, {tx_req, fast_vld, ilv_vld}, 4);
  endtask

  task automatic t_reset;
    check(tx_req == 1, "R1 tx_req", tx_req, 1);
    check(!fast_vld && !ilv_vld && !fast_start && !ilv_start, "R1 lanes idle",
          {fast_vld, ilv_vld, fast_start, ilv_start}, 0);
    check(!rx_val && !rx_frame, "R1 rx idle", {rx_val, rx_frame}, 0);
  endtask

  task automatic t_register_routing;
    send_byte(8'hB4, 1'b1, 0, 1'b0, 0, "R4 reg fast");
    write_cfg(1'b1, 1'b0);
    send_byte(8'h2D, 1'b0, 0, 1'b1, 0, "R4 reg ilv");
    write_cfg(1'b0, 1'b0);
    send_byte(8'h96, 1'b1, 0, 1'b0, 0, "R2 reg fast back");
  endtask

  task automatic t_no_overwrite;
    @(negedge clk);
    tx_val = 1; tx_byte = 8'hC3;
    @(negedge clk);
    tx_byte = 8'h5A;
    check_pairs(8'hC3, 1'b0, 0, "R3 held byte");
    check(tx_req && !fast_vld, "R3 gap before next", {tx_req, fast_vld}, 2);
    @(negedge clk);
    tx_val = 0;
    check_pairs(8'h5A, 1'b0, 0, "R3 next byte");
  endtask

  task automatic t_address_routing;
    write_cfg(1'b0, 1'b1);
    send_byte(8'hE1, 1'b1, 0, 1'b1, 0, "R5 addr ilv");
    send_byte(8'h1E, 1'b0, 0, 1'b0, 0, "R5 addr fast");
    write_cfg(1'b1, 1'b1);
    send_byte(8'h78, 1'b0, 0, 1'b0, 0, "R5 addr overrides reg");
    write_cfg(1'b0, 1'b0);
  endtask

  task automatic t_midbyte_change;
    @(negedge clk);
    tx_val = 1; tx_byte = 8'h69;
    @(negedge clk);
    tx_val = 0;
    fork
      check_pairs(8'h69, 1'b0, 0, "R6 mid change");
      begin
        cfg_we = 1; cfg_path = 1; cfg_mode = 1; tx_addr = 1;
        @(negedge clk);
        cfg_we = 0;
      end
    join
    check(!ilv_vld && !fast_vld, "R6 no leftover", {fast_vld, ilv_vld}, 0);
    write_cfg(1'b0, 1'b0);
    tx_addr = 0;
  endtask

  task automatic t_superframe;
    @(negedge clk);
    tx_sof = 1;
    @(negedge clk);
    tx_sof = 0;
    repeat (2) @(negedge clk);
    send_byte(8'h0F, 0, 0, 1'b0, 1, "R7 after pulse");
    send_byte(8'hF0, 0, 0, 1'b0, 0, "R7 second byte");
    write_cfg(1'b1, 1'b0);
    send_byte(8'hA5, 0, 1, 1'b1, 1, "R7 pulse on accept");
    send_byte(8'h5A, 0, 0, 1'b1, 0, "R7 no repeat");
    write_cfg(1'b0, 1'b0);
  endtask

  task automatic rx_pairs(input logic [7:0] b, input logic path, input logic st,
                          input int npairs, input bit junk_other);
    for (int i = 0; i < npairs; i++) begin
      @(negedge clk);
      if (path) begin
        rx_ilv_vld = 1; rx_ilv_l0 = b[2*i]; rx_ilv_l1 = b[2*i+1]; rx_ilv_start = st && i == 0;
        rx_fast_vld = junk_other; rx_fast_l0 = ~b[2*i]; rx_fast_l1 = ~b[2*i+1]; rx_fast_start = junk_other;
      end else begin
        rx_fast_vld = 1; rx_fast_l0 = b[2*i]; rx_fast_l1 = b[2*i+1]; rx_fast_start = st && i == 0;
        rx_ilv_vld = junk_other; rx_ilv_l0 = ~b[2*i]; rx_ilv_l1 = ~b[2*i+1]; rx_ilv_start = junk_other;
      end
      if (i < 3) check(!rx_val || npairs < 4, "R8 no early rx_val", rx_val, 0);
    end
    @(negedge clk);
    rx_fast_vld = 0; rx_ilv_vld = 0; rx_fast_start = 0; rx_ilv_start = 0;
  endtask

  task automatic rx_expect(input logic [7:0] b, input logic fr, input string tag);
    check(rx_val == 1, {tag, " rx_val"}, rx_val, 1);
    check(rx_byte == b, {tag, " rx_byte"}, rx_byte, b);
    check(rx_frame == fr, {tag, " rx_frame"}, rx_frame, fr);
    @(negedge clk);
    check(rx_val == 0, {tag, " rx_val one cycle"}, rx_val, 0);
  endtask

  task automatic t_receive;
    rx_pairs(8'hB2, 1'b0, 0, 4, 0);
    rx_expect(8'hB2, 0, "R8 fast");
    rx_pairs(8'h4D, 1'b0, 0, 4, 1);
    rx_expect(8'h4D, 0, "R8 other path ignored");
    write_cfg(1'b1, 1'b0);
    rx_pairs(8'h9C, 1'b1, 0, 4, 1);
    rx_expect(8'h9C, 0, "R8 ilv");
    rx_pairs(8'h33, 1'b0, 0, 4, 0);
    check(rx_val == 0, "R8 unselected path no byte", rx_val, 0);
    write_cfg(1'b0, 1'b0);
  endtask

  task automatic t_rx_align;
    rx_pairs(8'hFF, 1'b0, 0, 2, 0);
    check(rx_val == 0, "R9 partial no byte", rx_val, 0);
    rx_pairs(8'h72, 1'b0, 1, 4, 0);
    rx_expect(8'h72, 1, "R9 realigned frame");
    rx_pairs(8'h8D, 1'b0, 0, 4, 0);
    rx_expect(8'h8D, 0, "R9 following byte");
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_register_routing;
    t_no_overwrite;
    t_address_routing;
    t_midbyte_change;
    t_superframe;
    t_receive;
    t_rx_align;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule